// File: doc/BRIEF.md
# Byte-Port Message Responder (device side)

This block is the device end of a byte-wide, three-register host port used to carry management messages. A host sequencer writes a control code and a data byte, then sets a busy bit in the flags register to hand the step over. On the next clock the responder applies the code, updates a status code and a data byte that the host reads back, and clears busy. A message moves in two phases. In the write phase the host pushes request bytes, and the responder forwards them on a request stream that carries an end marker. In the read phase the host pulls bytes from a response buffer that another agent has loaded, by length, on the response side.

Readiness is shown by two flags. Transmit-ready means the host may push the next write byte. Receive-ready means a response byte is waiting. Three further flag bits mirror attention inputs: a system interrupt, pending event data and pending message data. Every result of a step comes back through the shared status and data registers: phase status codes, plus a single error byte at the end of a phase. Interpreting the request and building the response are left to the agents on the two stream sides.

Top module: `msgport_resp`

## Requirements
- R1: The register offsets are data at 0, control/status at 1 and flags at 2; offset 3 reads 0x00. After reset the data register reads 0x00, status reads 0xC0 and flags read 0x00 with all attention inputs low.
- R2: A host write to offset 2 with bit 0 set raises busy (flags bit 0), which reads 1 in the following cycle. The latched control code and data byte are applied on the next clock edge, which also clears busy. Status never changes except on that edge.
- R3: Get-status (0x40) sets status 0xC0. Data becomes 0x00 when idle or awaiting a response (the await is kept). Data becomes 0x01 (aborted) when a write or read phase is open, and the block returns to idle.
- R4: Write-start (0x41, accepted only when idle), write-next (0x42) and write-end (0x43) set status 0xC1, 0xC2 and 0xC3. Each accepted byte appears once on the request stream, in order, and write-end carries the end marker. Transmit-ready (flags bit 6) is high exactly while a write phase is open.
- R5: After write-end, data reads 0x00 and the block awaits a response. If more than REQ_MAX bytes were written, data reads 0x05 (buffer full), bytes past REQ_MAX are not forwarded, the end beat carries the drop flag, and the block goes idle.
- R6: Receive-ready (flags bit 7) is high while awaiting with a response loaded, or during readout. Read-start (0x44) while awaiting, with no loaded response of at least 2 bytes, gives status 0xC0 and data 0x03 (no response) and keeps the await.
- R7: Read-start with a loaded response sets status 0xC4 and shows response byte 0 in data. Each read-next (0x45) advances one byte and shows it, with status 0xC5, or 0xC6 when that byte is the final one.
- R8: Read-end (0x46) after the final byte sets status 0xC0 and data 0x00, pulses the response-done output for one cycle, and returns to idle.
- R9: A code out of sequence (a write code outside its phase, read-next at the final byte, read-end before it, a read code outside readout) or an unknown code gives status 0xC0, data 0x02 (illegal control) and idle. An open write phase it closes emits an end beat with the drop flag and data 0x00.
- R10: Flags bits 4, 3 and 2 follow attention inputs 2, 1 and 0 (interrupt, event data, message data).
- R11: A host write to offset 2 with bit 0 clear changes no flag and starts no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register offset for read and write |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Selected register read value (combinational) |
| attn | input | 3 | Attention inputs: 2 interrupt, 1 event data, 0 message data |
| req_valid | output | 1 | Request stream beat valid |
| req_data | output | 8 | Request stream byte |
| req_last | output | 1 | End marker of the request |
| req_drop | output | 1 | With req_last: discard the request |
| rsp_valid | input | 1 | A response is loaded |
| rsp_len | input | RSP_AW+1 | Response length in bytes |
| rsp_idx | output | RSP_AW | Index of the response byte being shown |
| rsp_byte | input | 8 | Response byte at rsp_idx |
| rsp_done | output | 1 | One-cycle pulse when the response has been read out |

## Verification
The bench targets the step boundaries where the sequencing is easiest to get wrong:
- A write of exactly REQ_MAX bytes and one of REQ_MAX+2. A design that is off by one would report buffer-full early or forward an extra byte.
- Read-next issued at the final byte, and read-end issued before it. A design that is lax here would run off the end of the response or complete it early.
- Aborting an open write, either by get-status or by an illegal code. A design that forgot the drop beat would leave the request stream without an end marker.
- Get-status while awaiting a response, a length-1 response, and readout of a 2-byte response. Wrong handling shows up as a lost await, a false 0xC4, or 0xC5 where 0xC6 is due.

// File: rtl/msgport_pkg.sv
package msgport_pkg;
  // status codes reported at offset 1
  localparam logic [7:0] ST_READY  = 8'hC0;
  localparam logic [7:0] ST_WSTART = 8'hC1;
  localparam logic [7:0] ST_WNEXT  = 8'hC2;
  localparam logic [7:0] ST_WEND   = 8'hC3;
  localparam logic [7:0] ST_RSTART = 8'hC4;
  localparam logic [7:0] ST_RNEXT  = 8'hC5;
  localparam logic [7:0] ST_RFINAL = 8'hC6;
  // control codes written at offset 1
  localparam logic [7:0] CC_GETST  = 8'h40;
  localparam logic [7:0] CC_WSTART = 8'h41;
  localparam logic [7:0] CC_WNEXT  = 8'h42;
  localparam logic [7:0] CC_WEND   = 8'h43;
  localparam logic [7:0] CC_RSTART = 8'h44;
  localparam logic [7:0] CC_RNEXT  = 8'h45;
  localparam logic [7:0] CC_REND   = 8'h46;
  // end-of-phase error bytes
  localparam logic [7:0] ER_NONE   = 8'h00;
  localparam logic [7:0] ER_ABORT  = 8'h01;
  localparam logic [7:0] ER_ILLCTL = 8'h02;
  localparam logic [7:0] ER_NORSP  = 8'h03;
  localparam logic [7:0] ER_FULL   = 8'h05;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_AWAIT = 2'd2,
    PH_READ  = 2'd3
  } phase_t;
endpackage

// File: rtl/msgport_busif.sv
module msgport_busif (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic [7:0] data_val,
  input  logic [7:0] status_val,
  input  logic [7:0] flags_val,
  output logic [7:0] bus_rdata,
  output logic [7:0] ctl_q,
  output logic [7:0] wdat_q,
  output logic       busy_q
);
  logic we_data, we_ctl, busy_set, busy_d;

  always_comb begin
    we_data  = bus_wr && (bus_sel == 2'd0);
    we_ctl   = bus_wr && (bus_sel == 2'd1);
    busy_set = bus_wr && (bus_sel == 2'd2) && bus_wdata[0];
    // busy lives one cycle: the step is applied on the edge that clears it
    busy_d   = busy_set;
  end

  always_comb begin
    unique case (bus_sel)
      2'd0:    bus_rdata = data_val;
      2'd1:    bus_rdata = status_val;
      2'd2:    bus_rdata = flags_val;
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= 8'h00;
      wdat_q <= 8'h00;
      busy_q <= 1'b0;
    end else begin
      if (we_ctl)  ctl_q  <= bus_wdata;
      if (we_data) wdat_q <= bus_wdata;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/msgport_reqgate.sv
module msgport_reqgate #(
  parameter int REQ_MAX = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       take,
  input  logic       fin,
  input  logic       abandon,
  input  logic [7:0] byte_in,
  output logic       over,
  output logic       req_valid,
  output logic [7:0] req_data,
  output logic       req_last,
  output logic       req_drop
);
  localparam int CW = $clog2(REQ_MAX + 2);
  localparam logic [CW-1:0] CAP = CW'(REQ_MAX);

  logic [CW-1:0] cnt_q, cnt_d, base;
  logic          v_d, l_d, dr_d;
  logic [7:0]    d_d;

  always_comb begin
    base  = clr ? '0 : cnt_q;
    cnt_d = cnt_q;
    if (take) cnt_d = (base > CAP) ? base : base + CW'(1);
    over  = cnt_d > CAP;
    v_d   = 1'b0;
    l_d   = 1'b0;
    dr_d  = 1'b0;
    d_d   = byte_in;
    if (abandon) begin
      v_d  = 1'b1;
      l_d  = 1'b1;
      dr_d = 1'b1;
      d_d  = 8'h00;
    end else if (take && fin) begin
      v_d  = 1'b1;
      l_d  = 1'b1;
      dr_d = over;
    end else if (take && (base < CAP)) begin
      v_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      req_valid <= 1'b0;
      req_data  <= 8'h00;
      req_last  <= 1'b0;
      req_drop  <= 1'b0;
    end else begin
      if (take) cnt_q <= cnt_d;
      req_valid <= v_d;
      req_data  <= d_d;
      req_last  <= l_d;
      req_drop  <= dr_d;
    end
  end
endmodule

// File: rtl/msgport_fsm.sv
module msgport_fsm
  import msgport_pkg::*;
#(
  parameter int RSP_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [7:0]        code,
  input  logic              rsp_valid,
  input  logic [RSP_AW:0]   rsp_len,
  input  logic              req_over,
  output phase_t            phase_q,
  output logic [7:0]        status_q,
  output logic [7:0]        data_q,
  output logic [RSP_AW-1:0] idx_q,
  output logic              done_q,
  output logic              g_clr,
  output logic              g_take,
  output logic              g_fin,
  output logic              g_abandon
);
  localparam int LW = RSP_AW + 1;

  phase_t            phase_d;
  logic [7:0]        status_d, data_d;
  logic [RSP_AW-1:0] idx_d;
  logic              done_d, ill, at_last, nxt_last, rsp_ok;
  logic [LW-1:0]     last_pos;

  always_comb begin
    last_pos = rsp_len - LW'(1);
    at_last  = {1'b0, idx_q} == last_pos;
    nxt_last = ({1'b0, idx_q} + LW'(1)) == last_pos;
    rsp_ok   = rsp_valid && (rsp_len >= LW'(2));
  end

  always_comb begin
    phase_d   = phase_q;
    status_d  = status_q;
    data_d    = data_q;
    idx_d     = idx_q;
    done_d    = 1'b0;
    ill       = 1'b0;
    g_clr     = 1'b0;
    g_take    = 1'b0;
    g_fin     = 1'b0;
    g_abandon = 1'b0;
    if (step) begin
      unique case (code)
        CC_GETST: begin
          status_d = ST_READY;
          if (phase_q == PH_WRITE || phase_q == PH_READ) begin
            data_d    = ER_ABORT;
            phase_d   = PH_IDLE;
            g_abandon = (phase_q == PH_WRITE);
          end else begin
            data_d = ER_NONE;
          end
        end
        CC_WSTART: begin
          if (phase_q == PH_IDLE) begin
            g_clr    = 1'b1;
            g_take   = 1'b1;
            status_d = ST_WSTART;
            data_d   = ER_NONE;
            phase_d  = PH_WRITE;
          end else ill = 1'b1;
        end
        CC_WNEXT: begin
          if (phase_q == PH_WRITE) begin
            g_take   = 1'b1;
            status_d = ST_WNEXT;
            data_d   = ER_NONE;
          end else ill = 1'b1;
        end
        CC_WEND: begin
          if (phase_q == PH_WRITE) begin
            g_take   = 1'b1;
            g_fin    = 1'b1;
            status_d = ST_WEND;
            data_d   = req_over ? ER_FULL : ER_NONE;
            phase_d  = req_over ? PH_IDLE : PH_AWAIT;
          end else ill = 1'b1;
        end
        CC_RSTART: begin
          if (phase_q == PH_AWAIT) begin
            if (rsp_ok) begin
              idx_d    = '0;
              status_d = ST_RSTART;
              phase_d  = PH_READ;
            end else begin
              status_d = ST_READY;
              data_d   = ER_NORSP;
            end
          end else ill = 1'b1;
        end
        CC_RNEXT: begin
          if (phase_q == PH_READ && !at_last) begin
            idx_d    = idx_q + RSP_AW'(1);
            status_d = nxt_last ? ST_RFINAL : ST_RNEXT;
          end else ill = 1'b1;
        end
        CC_REND: begin
          if (phase_q == PH_READ && at_last) begin
            status_d = ST_READY;
            data_d   = ER_NONE;
            phase_d  = PH_IDLE;
            done_d   = 1'b1;
          end else ill = 1'b1;
        end
        default: ill = 1'b1;
      endcase
      if (ill) begin
        status_d  = ST_READY;
        data_d    = ER_ILLCTL;
        phase_d   = PH_IDLE;
        g_abandon = (phase_q == PH_WRITE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      status_q <= ST_READY;
      data_q   <= ER_NONE;
      idx_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      if (step) begin
        phase_q  <= phase_d;
        status_q <= status_d;
        data_q   <= data_d;
        idx_q    <= idx_d;
      end
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/msgport_resp.sv
module msgport_resp
  import msgport_pkg::*;
#(
  parameter int REQ_MAX = 32,
  parameter int RSP_AW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [2:0]        attn,
  output logic              req_valid,
  output logic [7:0]        req_data,
  output logic              req_last,
  output logic              req_drop,
  input  logic              rsp_valid,
  input  logic [RSP_AW:0]   rsp_len,
  output logic [RSP_AW-1:0] rsp_idx,
  input  logic [7:0]        rsp_byte,
  output logic              rsp_done
);
  logic [7:0] ctl_q, wdat_q, status_q, data_q, data_val, flags_val;
  logic       busy_q, rx_rdy, tx_rdy, req_over;
  logic       g_clr, g_take, g_fin, g_abandon;
  phase_t     phase_q;

  always_comb begin
    tx_rdy    = (phase_q == PH_WRITE);
    rx_rdy    = (phase_q == PH_READ) || ((phase_q == PH_AWAIT) && rsp_valid);
    data_val  = (phase_q == PH_READ) ? rsp_byte : data_q;
    // bit7 rx, bit6 tx, bits4..2 attention, bit0 busy
    flags_val = {rx_rdy, tx_rdy, 1'b0, attn, 1'b0, busy_q};
  end

  msgport_busif u_bus (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .data_val(data_val), .status_val(status_q),
    .flags_val(flags_val), .bus_rdata(bus_rdata), .ctl_q(ctl_q),
    .wdat_q(wdat_q), .busy_q(busy_q)
  );

  msgport_fsm #(.RSP_AW(RSP_AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .step(busy_q), .code(ctl_q),
    .rsp_valid(rsp_valid), .rsp_len(rsp_len), .req_over(req_over),
    .phase_q(phase_q), .status_q(status_q), .data_q(data_q),
    .idx_q(rsp_idx), .done_q(rsp_done), .g_clr(g_clr), .g_take(g_take),
    .g_fin(g_fin), .g_abandon(g_abandon)
  );

  msgport_reqgate #(.REQ_MAX(REQ_MAX)) u_req (
    .clk(clk), .rst_n(rst_n), .clr(g_clr), .take(g_take), .fin(g_fin),
    .abandon(g_abandon), .byte_in(wdat_q), .over(req_over),
    .req_valid(req_valid), .req_data(req_data), .req_last(req_last),
    .req_drop(req_drop)
  );
endmodule

// File: rtl/msgport_chk.sv
module msgport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic [1:0] phase,
  input logic [7:0] status,
  input logic       req_valid,
  input logic       req_last,
  input logic       req_drop,
  input logic       rsp_done
);
  // R2: status moves only on the edge that applies a handed-over step
  a_r2_status_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(status));

  // R4: request beats only follow an applied step
  a_r4_beat_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(busy));

  // R5: drop flag only on an end beat
  a_r5_drop_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    req_drop |-> (req_valid && req_last));

  // R7: readout phase always reports a read status code
  a_r7_read_status: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3) |-> (status == 8'hC4 || status == 8'hC5 || status == 8'hC6));

  // R4: write phase always reports start or next status
  a_r4_write_status: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1) |-> (status == 8'hC1 || status == 8'hC2));

  // R8: completion leaves the block idle and ready, for one cycle only
  a_r8_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (status == 8'hC0 && phase == 2'd0));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind msgport_resp msgport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .phase(phase_q),
  .status(status_q), .req_valid(req_valid), .req_last(req_last),
  .req_drop(req_drop), .rsp_done(rsp_done)
);

// File: tb/sim_msgport_resp.sv
module sim_msgport_resp;
  localparam int CLK_PERIOD = 10;
  localparam int TB_REQ = 6;
  localparam int AW = 5;
  localparam int MI = 0, MW = 1, MA = 2, MR = 3;

  logic          clk, rst_n;
  logic [1:0]    bus_sel;
  logic          bus_wr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic [2:0]    attn;
  logic          req_valid, req_last, req_drop, rsp_valid, rsp_done;
  logic [7:0]    req_data, rsp_byte;
  logic [AW:0]   rsp_len;
  logic [AW-1:0] rsp_idx;
  logic [7:0]    rsp_mem [0:31];

  int nvec = 0, nmis = 0;
  bit started = 0, in_result = 0, finished = 0;

  // reference model state
  int m_phase, m_cnt, m_idx;
  logic [7:0] m_status, m_data, m_bdata;
  bit m_bv, m_bl, m_bd, m_done;
  string m_tag;

  assign rsp_byte = rsp_mem[rsp_idx];

  msgport_resp #(.REQ_MAX(TB_REQ), .RSP_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .attn(attn),
    .req_valid(req_valid), .req_data(req_data), .req_last(req_last),
    .req_drop(req_drop), .rsp_valid(rsp_valid), .rsp_len(rsp_len),
    .rsp_idx(rsp_idx), .rsp_byte(rsp_byte), .rsp_done(rsp_done)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_flags();
    logic rx, tx;
    rx = (m_phase == MR) || (m_phase == MA && rsp_valid);
    tx = (m_phase == MW);
    return {rx, tx, 1'b0, attn, 2'b00};
  endfunction

  function automatic logic [7:0] exp_data();
    return (m_phase == MR) ? rsp_mem[m_idx] : m_data;
  endfunction

  // per-clock compare of the stream outputs
  always @(negedge clk) begin
    #3;
    if (started && rst_n && !finished) begin
      chk("R4 req_valid", {7'd0, req_valid}, {7'd0, in_result && m_bv});
      if (in_result && m_bv) begin
        chk("R4 req_data", req_data, m_bdata);
        chk("R4 req_last", {7'd0, req_last}, {7'd0, m_bl});
        chk("R5 req_drop", {7'd0, req_drop}, {7'd0, m_bd});
      end
      chk("R8 rsp_done", {7'd0, rsp_done}, {7'd0, in_result && m_done});
    end
  end

  task automatic push_byte(input logic [7:0] b, input bit fin);
    bit room;
    room  = (m_cnt < TB_REQ);
    m_cnt = (m_cnt > TB_REQ) ? m_cnt : m_cnt + 1;
    if (fin) begin
      m_bv = 1; m_bl = 1; m_bd = (m_cnt > TB_REQ); m_bdata = b;
    end else if (room) begin
      m_bv = 1; m_bdata = b;
    end
  endtask

  task automatic model(input logic [7:0] c, input logic [7:0] b);
    bit ill;
    ill = 0; m_bv = 0; m_bl = 0; m_bd = 0; m_bdata = 8'h00; m_done = 0;
    case (c)
      8'h40: begin
        m_tag = "R3"; m_status = 8'hC0;
        if (m_phase == MW) begin
          m_bv = 1; m_bl = 1; m_bd = 1; m_data = 8'h01; m_phase = MI;
        end else if (m_phase == MR) begin
          m_data = 8'h01; m_phase = MI;
        end else m_data = 8'h00;
      end
      8'h41: if (m_phase == MI) begin
        m_tag = "R4"; m_cnt = 0; push_byte(b, 0);
        m_status = 8'hC1; m_data = 8'h00; m_phase = MW;
      end else ill = 1;
      8'h42: if (m_phase == MW) begin
        m_tag = "R4"; push_byte(b, 0); m_status = 8'hC2; m_data = 8'h00;
      end else ill = 1;
      8'h43: if (m_phase == MW) begin
        m_tag = "R5"; push_byte(b, 1); m_status = 8'hC3;
        m_data  = (m_cnt > TB_REQ) ? 8'h05 : 8'h00;
        m_phase = (m_cnt > TB_REQ) ? MI : MA;
      end else ill = 1;
      8'h44: if (m_phase == MA) begin
        if (rsp_valid && rsp_len >= 2) begin
          m_tag = "R7"; m_idx = 0; m_status = 8'hC4; m_phase = MR;
        end else begin
          m_tag = "R6"; m_status = 8'hC0; m_data = 8'h03;
        end
      end else ill = 1;
      8'h45: if (m_phase == MR && m_idx != int'(rsp_len) - 1) begin
        m_tag = "R7"; m_idx++;
        m_status = (m_idx == int'(rsp_len) - 1) ? 8'hC6 : 8'hC5;
      end else ill = 1;
      8'h46: if (m_phase == MR && m_idx == int'(rsp_len) - 1) begin
        m_tag = "R8"; m_status = 8'hC0; m_data = 8'h00; m_phase = MI; m_done = 1;
      end else ill = 1;
      default: ill = 1;
    endcase
    if (ill) begin
      m_tag = "R9";
      if (m_phase == MW) begin m_bv = 1; m_bl = 1; m_bd = 1; end
      m_status = 8'hC0; m_data = 8'h02; m_phase = MI;
    end
  endtask

  task automatic bwr(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    bus_sel = sel; bus_wdata = val; bus_wr = 1;
    @(posedge clk);
    #1 bus_wr = 0;
  endtask

  task automatic step(input logic [7:0] c, input logic [7:0] b);
    bwr(2'd1, c);
    bwr(2'd0, b);
    model(c, b);
    bwr(2'd2, 8'h01);
    @(negedge clk);
    bus_sel = 2'd2;
    #1 chk("R2 busy raised", {7'd0, bus_rdata[0]}, 8'h01);
    @(negedge clk);
    in_result = 1;
    bus_sel = 2'd1;
    #1 chk({m_tag, " status"}, bus_rdata, m_status);
    bus_sel = 2'd0;
    #1 chk({m_tag, " data"}, bus_rdata, exp_data());
    bus_sel = 2'd2;
    #1 chk({m_tag, " R2 flags after step"}, bus_rdata, exp_flags());
    @(posedge clk);
    #1 in_result = 0;
  endtask

  task automatic send_req(input int n, input logic [7:0] base);
    step(8'h41, base);
    for (int i = 1; i < n - 1; i++) step(8'h42, base + 8'(i));
    step(8'h43, base + 8'(n - 1));
  endtask

  task automatic load_rsp(input int n, input logic [7:0] base);
    for (int i = 0; i < 32; i++) rsp_mem[i] = base + 8'(i * 7);
    rsp_len = (AW+1)'(n);
    rsp_valid = 1;
  endtask

  task automatic read_all(input int n);
    step(8'h44, 8'h00);
    for (int i = 1; i < n; i++) step(8'h45, 8'h00);
    step(8'h46, 8'h00);
    rsp_valid = 0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, input string tag, input logic [7:0] exp);
    @(negedge clk);
    bus_sel = sel;
    #1 chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nvec++; nmis++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_wdata = 0; attn = 0;
    rsp_valid = 0; rsp_len = 0;
    for (int i = 0; i < 32; i++) rsp_mem[i] = 8'h00;
    m_phase = MI; m_cnt = 0; m_idx = 0; m_status = 8'hC0; m_data = 8'h00;
    m_bv = 0; m_bl = 0; m_bd = 0; m_done = 0; m_bdata = 0; m_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    started = 1;

    // R1: reset state and offsets
    rd_reg(2'd0, "R1 data at reset", 8'h00);
    rd_reg(2'd1, "R1 status at reset", 8'hC0);
    rd_reg(2'd2, "R1 flags at reset", 8'h00);
    rd_reg(2'd3, "R1 unused offset", 8'h00);

    // R10: attention bits
    attn = 3'b101;
    rd_reg(2'd2, "R10 attn 101", 8'h14);
    attn = 3'b010;
    rd_reg(2'd2, "R10 attn 010", 8'h08);
    attn = 3'b000;

    // R11: flag write without busy bit does nothing
    bwr(2'd1, 8'h41);
    bwr(2'd2, 8'hFE);
    rd_reg(2'd2, "R11 flags after write", 8'h00);
    @(negedge clk);
    rd_reg(2'd1, "R11 status unchanged", 8'hC0);
    rd_reg(2'd2, "R11 no tx ready", 8'h00);

    // R3, R4, R5, R6, R7, R8: full transaction
    step(8'h40, 8'h00);
    send_req(5, 8'h18);
    step(8'h44, 8'h00);           // R6 no response loaded
    load_rsp(4, 8'h1C);
    rd_reg(2'd2, "R6 rx ready when loaded", 8'h80);
    step(8'h40, 8'h00);           // R3 await kept
    read_all(4);

    // R5 boundary: exactly REQ_MAX, then REQ_MAX+2
    send_req(TB_REQ, 8'h30);
    load_rsp(2, 8'h50);           // R7 two-byte response
    read_all(2);
    send_req(TB_REQ + 2, 8'h60);
    rd_reg(2'd2, "R5 idle after overflow", 8'h00);

    // R9: out-of-sequence and unknown codes
    step(8'h45, 8'h00);
    step(8'h46, 8'h00);
    step(8'h47, 8'h00);
    step(8'h42, 8'h11);
    step(8'h41, 8'hA0);
    step(8'h42, 8'hA1);
    step(8'h44, 8'h00);           // closes write with drop
    step(8'h41, 8'hB0);
    step(8'h41, 8'hB1);           // write-start inside write phase

    // R3 abort of write and read phases
    step(8'h41, 8'hC0);
    step(8'h40, 8'h00);
    send_req(3, 8'h70);
    load_rsp(5, 8'h90);
    step(8'h44, 8'h00);
    step(8'h45, 8'h00);
    step(8'h40, 8'h00);

    // R9 read-end early and read-next past the end
    send_req(2, 8'h80);
    step(8'h44, 8'h00);
    step(8'h46, 8'h00);
    send_req(2, 8'h81);
    load_rsp(3, 8'h05);
    step(8'h44, 8'h00);
    step(8'h45, 8'h00);
    step(8'h45, 8'h00);
    step(8'h45, 8'h00);

    // R6: length-1 response counts as no response
    send_req(2, 8'h82);
    load_rsp(1, 8'hEE);
    step(8'h44, 8'h00);
    load_rsp(3, 8'h21);
    read_all(3);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  end
endmodule